// File: doc/BRIEF.md
# Serial Light-Sensor Sample Reader

This block is a SPI master that fetches one 8-bit reading from a serial light-sensor converter each time it is started. A one-cycle start request in the idle state pulls chip select low. The block then produces a serial clock from the system clock through a fixed half-period divider. It captures sixteen bits from the converter's data line on the rising clock edges and releases chip select half a serial-clock period after the last capture.

Each reply has a fixed layout. The first captured bit carries no information. Three bits that must be zero come next, then the eight sample bits with the most significant bit first, then four more bits that must be zero. The block removes the framing and presents the sample together with an error flag that reports any framing bit captured as one. A single-cycle valid strobe marks the result, and it comes one full serial-clock period after chip select rises, so back-to-back reads always keep the required idle gap. The divider is a parameter. A setting that would put the serial clock outside 1 to 4 MHz for the given system clock frequency is rejected at elaboration.

Top module: `adc_frame_reader`

## Requirements
- R1: After reset the outputs are cs_n = 1, sclk = 1, busy = 0 and valid = 0.
- R2: A start that is high in an idle cycle drives cs_n low and busy high in the next cycle.
- R3: While cs_n is low, sclk first falls HALF_DIV system cycles after cs_n falls and then toggles every HALF_DIV cycles. A frame has exactly 16 sclk rising edges, and sclk is high whenever cs_n is high.
- R4: miso is sampled at each sclk rising edge. Captures 5 to 12, counted from 1 after cs_n falls, form sample[7:0], with capture 5 as bit 7.
- R5: frame_err is 1 exactly when any of captures 2, 3, 4, 13, 14, 15 or 16 was 1. The value of capture 1 has no effect on sample or frame_err.
- R6: cs_n rises HALF_DIV system cycles after the 16th sclk rising edge, so cs_n is low for 33·HALF_DIV cycles per frame.
- R7: valid is high for exactly one cycle, 2·HALF_DIV cycles after cs_n rises. sample and frame_err keep their values until the next valid.
- R8: busy is high from the cycle after the start is accepted up to the cycle before valid, which is 35·HALF_DIV cycles, and busy is low while valid is high.
- R9: A start that arrives while busy is high is ignored. The current frame keeps its length, and no further frame starts.
- R10: Between consecutive frames, cs_n stays high for at least 2·HALF_DIV cycles, even when start is held high. With start held high the gap is exactly 2·HALF_DIV + 1 cycles.
- R11: The serial clock rate, SYS_CLK_HZ / (2·HALF_DIV), must lie between 1 MHz and 4 MHz inclusive. Any other setting is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Read request, sampled in idle cycles |
| miso | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idles high |
| busy | output | 1 | A read is in progress |
| valid | output | 1 | One-cycle strobe marking a new result |
| sample | output | 8 | Sample extracted from the last frame |
| frame_err | output | 1 | A framing bit of the last frame was captured as one |

## Verification
A divider counter that is out of step shows up as a wrong sclk phase within one half period. It also shifts the cs_n-low and busy lengths away from 33·HALF_DIV and 35·HALF_DIV, so those lengths are measured on every frame. An off-by-one in the capture counter or in the field positions corrupts sample or frame_err at the very next valid strobe. All 256 sample values are swept, and an error bit is injected into each framing position. A state machine that accepts a start too early shows up as a shortened cs_n-high gap, or as a second valid strobe in the same frame.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  localparam int DEAD_BITS   = 1;
  localparam int LEAD_ZEROS  = 3;
  localparam int DATA_W      = 8;
  localparam int TRAIL_ZEROS = 4;
  localparam int FRAME_LEN   = DEAD_BITS + LEAD_ZEROS + DATA_W + TRAIL_ZEROS;
  localparam int CNT_W       = $clog2(FRAME_LEN + 1);
  localparam int DATA_LSB    = TRAIL_ZEROS;

  localparam longint SCLK_MIN_HZ = 64'd1_000_000;
  localparam longint SCLK_MAX_HZ = 64'd4_000_000;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_SHIFT,
    ST_HOLD,
    ST_GAP
  } rd_state_t;

  // capture k (1-based) lands in frame bit FRAME_LEN-k
  function automatic logic [FRAME_LEN-1:0] zero_mask();
    logic [FRAME_LEN-1:0] m;
    m = '0;
    for (int k = 1; k <= FRAME_LEN; k++) begin
      if ((k > DEAD_BITS && k <= DEAD_BITS + LEAD_ZEROS) ||
          (k > DEAD_BITS + LEAD_ZEROS + DATA_W))
        m[FRAME_LEN-k] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/adc_sclk_gen.sv
module adc_sclk_gen #(
  parameter int HALF_DIV = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic toggle,
  output logic tick,
  output logic sclk
);

  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          sclk_q, sclk_d;

  always_comb begin
    tick  = run && (cnt_q == LAST);
    cnt_d = cnt_q;
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
    sclk_d = sclk_q;
    if (!run)        sclk_d = 1'b1;
    else if (toggle) sclk_d = ~sclk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk = sclk_q;

  AST_SCLK_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sclk_q) |-> ($past(tick) || !$past(run))); // R3

endmodule

// File: rtl/adc_frame_shift.sv
module adc_frame_shift
  import adc_rd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 capture,
  input  logic                 miso,
  output logic [FRAME_LEN-1:0] frame,
  output logic [CNT_W-1:0]     count
);

  logic [FRAME_LEN-1:0] frame_q, frame_d;
  logic [CNT_W-1:0]     count_q, count_d;

  always_comb begin
    frame_d = frame_q;
    count_d = count_q;
    if (clear) begin
      frame_d = '0;
      count_d = '0;
    end else if (capture) begin
      frame_d = {frame_q[FRAME_LEN-2:0], miso};
      count_d = count_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      count_q <= '0;
    end else begin
      frame_q <= frame_d;
      count_q <= count_d;
    end
  end

  assign frame = frame_q;
  assign count = count_q;

  AST_CAPTURE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> (count_q < CNT_W'(FRAME_LEN))); // R3

endmodule

// File: rtl/adc_frame_ctrl.sv
module adc_frame_ctrl
  import adc_rd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tick,
  input  logic sclk,
  input  logic last_rise,
  output logic cs_n,
  output logic busy,
  output logic run,
  output logic toggle,
  output logic capture,
  output logic clear,
  output logic done
);

  rd_state_t state_q, state_d;
  logic      gap2_q, gap2_d;
  logic      cs_n_q, cs_n_d;

  always_comb begin
    state_d = state_q;
    gap2_d  = gap2_q;
    toggle  = 1'b0;
    capture = 1'b0;
    clear   = 1'b0;
    done    = 1'b0;
    case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_SETUP;
        clear   = 1'b1;
        gap2_d  = 1'b0;
      end
      ST_SETUP: if (tick) begin
        toggle  = 1'b1;
        state_d = ST_SHIFT;
      end
      ST_SHIFT: if (tick) begin
        toggle = 1'b1;
        if (!sclk) begin
          capture = 1'b1;
          if (last_rise) state_d = ST_HOLD;
        end
      end
      ST_HOLD: if (tick) state_d = ST_GAP;
      ST_GAP: if (tick) begin
        if (gap2_q) begin
          state_d = ST_IDLE;
          done    = 1'b1;
        end else begin
          gap2_d = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    cs_n_d = !((state_d == ST_SETUP) || (state_d == ST_SHIFT) ||
               (state_d == ST_HOLD));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      gap2_q  <= 1'b0;
      cs_n_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      gap2_q  <= gap2_d;
      cs_n_q  <= cs_n_d;
    end
  end

  assign run  = (state_q != ST_IDLE);
  assign busy = run;
  assign cs_n = cs_n_q;

  AST_CS_ONLY_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n_q) |-> ($past(state_q) == ST_IDLE && $past(start))); // R9

  AST_HOLD_SCLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD) |-> sclk); // R6

endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
  import adc_rd_pkg::*;
#(
  parameter longint SYS_CLK_HZ = 64'd200_000_000,
  parameter int     HALF_DIV   = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              miso,
  output logic              cs_n,
  output logic              sclk,
  output logic              busy,
  output logic              valid,
  output logic [DATA_W-1:0] sample,
  output logic              frame_err
);

  localparam logic [FRAME_LEN-1:0] ZMASK = zero_mask();

  initial begin
    AST_SCLK_RANGE: assert ((SYS_CLK_HZ >= 2 * longint'(HALF_DIV) * SCLK_MIN_HZ) &&
                            (SYS_CLK_HZ <= 2 * longint'(HALF_DIV) * SCLK_MAX_HZ))
      else $error("serial clock divider out of range"); // R11
  end

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  logic                 tick, run, toggle, capture, clear, done, last_rise;
  logic [FRAME_LEN-1:0] frame;
  logic [CNT_W-1:0]     count;

  assign last_rise = (count == CNT_W'(FRAME_LEN - 1));

  adc_sclk_gen #(.HALF_DIV(HALF_DIV)) u_sclk (
    .clk(clk), .rst_n(rst_int_n), .run(run), .toggle(toggle),
    .tick(tick), .sclk(sclk)
  );

  adc_frame_shift u_shift (
    .clk(clk), .rst_n(rst_int_n), .clear(clear), .capture(capture),
    .miso(miso), .frame(frame), .count(count)
  );

  adc_frame_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .start(start), .tick(tick), .sclk(sclk),
    .last_rise(last_rise), .cs_n(cs_n), .busy(busy), .run(run),
    .toggle(toggle), .capture(capture), .clear(clear), .done(done)
  );

  logic [DATA_W-1:0] sample_q, sample_d;
  logic              ferr_q, ferr_d, valid_q;

  always_comb begin
    sample_d = sample_q;
    ferr_d   = ferr_q;
    if (done) begin
      sample_d = frame[DATA_LSB +: DATA_W];
      ferr_d   = |(frame & ZMASK);
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      sample_q <= '0;
      ferr_q   <= 1'b0;
      valid_q  <= 1'b0;
    end else begin
      sample_q <= sample_d;
      ferr_q   <= ferr_d;
      valid_q  <= done;
    end
  end

  assign valid     = valid_q;
  assign sample    = sample_q;
  assign frame_err = ferr_q;

  AST_CS_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    cs_n |-> sclk); // R3

  AST_VALID_ONE: assert property (@(posedge clk) disable iff (!rst_int_n)
    valid_q |=> !valid_q); // R7

  AST_VALID_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_int_n)
    valid_q |-> !busy); // R8

endmodule

// File: tb/adc_frame_reader_test.sv
module adc_frame_reader_test;

  localparam int     H   = 2;
  localparam longint SYS = 64'd8_000_000;

  logic clk = 1'b0;
  logic rst_n, start, miso;
  logic cs_n, sclk, busy, valid, frame_err;
  logic [7:0] sample;

  always #2.5 clk = ~clk;

  adc_frame_reader #(.SYS_CLK_HZ(SYS), .HALF_DIV(H)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .miso(miso), .cs_n(cs_n),
    .sclk(sclk), .busy(busy), .valid(valid), .sample(sample),
    .frame_err(frame_err)
  );

  int tests = 0, fails = 0;
  int cyc = 0;

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // converter model: bit k is driven on falling edge k of sclk
  logic [1:16] pat;
  int fall_idx = 0;
  always @(negedge sclk or posedge cs_n) begin
    if (cs_n) begin
      fall_idx = 0;
      miso <= 1'b0;
    end else begin
      fall_idx++;
      if (fall_idx <= 16) miso <= pat[fall_idx];
    end
  end

  // monitor, sampled away from the active edge
  bit   mon_on = 0, seen_fall;
  logic prev_sclk;
  int   cs_low_cnt, busy_cnt, rise_cnt, pre_fall_cnt, tail_cnt, valid_cnt;
  logic [7:0] got_data;
  logic got_ferr, busy_at_valid;

  always @(negedge clk) begin
    if (mon_on) begin
      if (!cs_n) cs_low_cnt++;
      if (busy) busy_cnt++;
      if (prev_sclk == 1'b0 && sclk == 1'b1) rise_cnt++;
      if (!cs_n && sclk && !seen_fall) pre_fall_cnt++;
      if (!cs_n && !sclk) seen_fall = 1;
      if (cs_n && busy) tail_cnt++;
      if (valid) begin
        valid_cnt++;
        got_data = sample;
        got_ferr = frame_err;
        busy_at_valid = busy;
      end
      prev_sclk = sclk;
    end
  end

  task automatic build(input logic [7:0] d, input int errpos, input logic dc);
    pat = '0;
    pat[1] = dc;
    for (int i = 0; i < 8; i++) pat[5+i] = d[7-i];
    if (errpos != 0) pat[errpos] = 1'b1;
  endtask

  task automatic clr_mon();
    cs_low_cnt = 0; busy_cnt = 0; rise_cnt = 0; pre_fall_cnt = 0;
    tail_cnt = 0; valid_cnt = 0; seen_fall = 0; prev_sclk = 1'b1;
  endtask

  task automatic wait_valid(input int want);
    int w = 0;
    while (valid_cnt < want && w < 3000) begin
      @(negedge clk);
      w++;
    end
    if (w >= 3000) chk("timeout", w, 0);
  endtask

  task automatic run_frame(input logic [7:0] d, input int errpos,
                           input logic dc, input bit extra);
    build(d, errpos, dc);
    clr_mon();
    mon_on = 1;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk("R2 cs_n low after start", int'(cs_n), 0);
    chk("R2 busy after start", int'(busy), 1);
    if (extra) begin
      repeat (20) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    wait_valid(1);
    repeat (3) @(negedge clk);
    mon_on = 0;
  endtask

  task automatic chk_timing();
    chk("R3 sclk rises per frame", rise_cnt, 16);
    chk("R3 first fall delay", pre_fall_cnt, H);
    chk("R6 cs_n low length", cs_low_cnt, 33 * H);
    chk("R8 busy length", busy_cnt, 35 * H);
    chk("R8 busy low with valid", int'(busy_at_valid), 0);
    chk("R7 valid after cs_n rise", tail_cnt, 2 * H);
    chk("R7 single valid", valid_cnt, 1);
  endtask

  initial begin
    int gap;
    rst_n = 1'b0;
    start = 1'b0;
    pat   = '0;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 cs_n in reset", int'(cs_n), 1);
    chk("R1 sclk in reset", int'(sclk), 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 cs_n idle", int'(cs_n), 1);
    chk("R1 sclk idle", int'(sclk), 1);
    chk("R1 busy idle", int'(busy), 0);
    chk("R1 valid idle", int'(valid), 0);

    // R4, R5: full sweep of the sample value, dead bit toggled
    for (int d = 0; d < 256; d++) begin
      run_frame(8'(d), 0, d[0], 0);
      chk("R4 sample value", int'(got_data), d);
      chk("R5 no framing error", int'(got_ferr), 0);
      chk_timing();
    end

    // R5: one error bit in each framing position
    for (int p = 2; p <= 16; p++) begin
      if (p >= 5 && p <= 12) continue;
      run_frame(8'hA5, p, 1'b0, 0);
      chk("R5 framing error flagged", int'(got_ferr), 1);
      chk("R5 sample kept with error", int'(got_data), 8'hA5);
    end
    run_frame(8'h3C, 1, 1'b1, 0);
    chk("R5 dead bit ignored", int'(got_ferr), 0);

    // R7 result held until next valid
    repeat (20) @(negedge clk);
    chk("R7 sample held", int'(sample), 8'h3C);
    chk("R7 valid stays low", int'(valid), 0);

    // R9 start during a frame is ignored
    run_frame(8'h5A, 0, 1'b0, 1);
    chk_timing();
    chk("R9 sample with extra start", int'(got_data), 8'h5A);
    repeat (10) @(negedge clk);
    chk("R9 no new frame cs_n", int'(cs_n), 1);
    chk("R9 no new frame busy", int'(busy), 0);

    // R10 back-to-back with start held high
    build(8'hC3, 0, 1'b0);
    clr_mon();
    mon_on = 1;
    @(negedge clk) start = 1'b1;
    while (cs_n) @(negedge clk);
    while (!cs_n) @(negedge clk);
    gap = 0;
    while (cs_n && gap < 1000) begin
      gap++;
      @(negedge clk);
    end
    chk("R10 gap at least one period", int'(gap >= 2 * H), 1);
    chk("R10 gap with start held", gap, 2 * H + 1);
    chk("R10 first frame sample", int'(got_data), 8'hC3);
    start = 1'b0;
    wait_valid(2);
    repeat (3) @(negedge clk);
    mon_on = 0;
    chk("R10 second frame sample", int'(got_data), 8'hC3);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule